// File: doc/BRIEF.md
# Shared-Medium Transmit Access Controller with Collision Backoff

This block is the transmit-side access controller of a half-duplex station on a shared Ethernet medium. A frame is loaded into an internal frame store as a byte stream. A start marker sets the write position to byte zero and a last marker ends loading. The controller then defers until the carrier-sense input shows an idle medium. It then sends the frame one byte per clock on a valid-qualified byte output. Frames shorter than the minimum length are extended with zero bytes.

While it sends, the controller watches a collision input. A collision cuts the frame off at once and a fixed jam pattern goes out in its place. The controller then waits a random number of slot times and retries the same frame from its first byte. The random count comes from a 16-bit LFSR and is masked to a window that doubles with each attempt, up to a cap. Slot times are counted on a slot-tick input supplied by the surroundings. When the attempt limit is reached, the frame is discarded and an error pulse is raised. Preamble, CRC and receive are handled elsewhere.

Top module: `csma_tx_ctrl`

## Requirements
- R1: After reset, `tx_valid_o`, `tx_done_o` and `tx_excess_o` are 0 and `in_ready_o` is 1.
- R2: While `in_ready_o` is 1, each cycle with `in_valid_i` high stores `in_data_i`. With `in_sof_i` high the byte goes to position 0, otherwise to the next position. A byte with `in_last_i` high is the final byte of the frame, and `in_ready_o` is 0 from the following cycle until the frame is finished or dropped.
- R3: After loading, no byte is emitted while `carrier_sense_i` is 1. In the first cycle where it is sampled 0, the controller commits to sending, and the first byte appears on the output in the cycle after that.
- R4: Once sending has begun, bytes go out on consecutive cycles in stored order, and `carrier_sense_i` has no effect on them.
- R5: A frame of fewer than 64 bytes is followed by zero bytes (0x00) up to 64 bytes in total. A longer frame is sent at its own length. `tx_done_o` pulses together with the final byte.
- R6: A collision sampled in a sending cycle replaces that cycle's byte with the first of 4 jam bytes of value 0xAA, sent on consecutive cycles. `collision_i` is ignored during the jam.
- R7: After the jam of the n-th collision of a frame (n < 16), the controller waits k pulses of `slot_tick_i` and then defers again. k is the LFSR value's low min(n,10) bits, and k = 0 means it defers in the very next cycle.
- R8: The LFSR holds `LFSR_SEED` after reset. It advances only when a backoff count is drawn: the count is taken from the value before the step, and the step shifts left, inserting bit15 xor bit13 xor bit12 xor bit10 at bit 0.
- R9: Each retry sends the frame again from its first stored byte.
- R10: On the 16th collision of a frame, `tx_excess_o` pulses with the last jam byte, the frame is discarded without a retry, and `in_ready_o` is 1 in that same cycle.
- R11: Input bytes offered while `in_ready_o` is 0 are ignored and leave the stored frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte present |
| in_data_i | input | 8 | Input frame byte |
| in_sof_i | input | 1 | Byte is the first of a frame |
| in_last_i | input | 1 | Byte is the last of a frame |
| in_ready_o | output | 1 | Controller accepts frame bytes |
| carrier_sense_i | input | 1 | Medium is busy |
| collision_i | input | 1 | Collision seen on the medium |
| slot_tick_i | input | 1 | One pulse per slot time |
| tx_valid_o | output | 1 | Output byte present |
| tx_data_o | output | 8 | Output byte (frame, pad or jam) |
| tx_done_o | output | 1 | Pulse with the last byte of a sent frame |
| tx_excess_o | output | 1 | Pulse when a frame is dropped after too many collisions |

## Verification
The bench aims at the points where the frame, the jam and the backoff meet. If it collides several cycles into a frame, a design that failed to rewind would restart mid-frame on the retry. If the collision were held through the jam, a design that re-armed on it would stretch or restart the jam. A design that forgot the pad would end short frames early, and one that padded long frames would add bytes. The longest run keeps the collision line high so that every attempt collides. An off-by-one in the attempt counter or in the window mask would drop the frame at the wrong attempt or wait the wrong number of slots, and that mismatch shows against a model that draws the backoff independently from the stated LFSR rule.

// File: rtl/txc_pkg.sv
package txc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEFER,
        ST_SEND,
        ST_JAM,
        ST_BACKOFF
    } txc_state_e;

    localparam int unsigned LFSR_W   = 16;
    localparam logic [7:0]  JAM_BYTE = 8'hAA;

    // one shift of the random source: taps 16,14,13,11
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] v);
        return {v[LFSR_W-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction
endpackage

// File: rtl/txc_frame_buf.sv
module txc_frame_buf #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/txc_lfsr.sv
module txc_lfsr
    import txc_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              step_i,
    output logic [LFSR_W-1:0] value_o
);
    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = step_i ? lfsr_next(lfsr_q) : lfsr_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lfsr_q <= SEED;
        else         lfsr_q <= lfsr_d;
    end

    assign value_o = lfsr_q;

    // R8
    lfsr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> $stable(lfsr_q));

    // R8
    lfsr_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_q != '0);
endmodule

// File: rtl/txc_draw.sv
module txc_draw #(
    parameter int unsigned MAX_EXP = 10,
    parameter int unsigned ATT_W   = 5,
    parameter int unsigned SRC_W   = 16
) (
    input  logic [ATT_W-1:0]   attempt_i,
    input  logic [SRC_W-1:0]   rand_i,
    output logic [MAX_EXP-1:0] slots_o
);
    // bit g of the window opens once the attempt number exceeds g
    for (genvar g = 0; g < MAX_EXP; g++) begin : g_win
        assign slots_o[g] = rand_i[g] & (int'(attempt_i) > g);
    end
endmodule

// File: rtl/csma_tx_ctrl.sv
module csma_tx_ctrl
    import txc_pkg::*;
#(
    parameter int unsigned       BUF_DEPTH     = 128,
    parameter int unsigned       MIN_LEN       = 64,
    parameter int unsigned       JAM_LEN       = 4,   // at least 2
    parameter int unsigned       ATTEMPT_LIMIT = 16,
    parameter int unsigned       MAX_EXP       = 10,
    parameter logic [LFSR_W-1:0] LFSR_SEED     = 16'hACE1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       in_valid_i,
    input  logic [7:0] in_data_i,
    input  logic       in_sof_i,
    input  logic       in_last_i,
    output logic       in_ready_o,
    input  logic       carrier_sense_i,
    input  logic       collision_i,
    input  logic       slot_tick_i,
    output logic       tx_valid_o,
    output logic [7:0] tx_data_o,
    output logic       tx_done_o,
    output logic       tx_excess_o
);
    localparam int unsigned AW    = $clog2(BUF_DEPTH);
    localparam int unsigned LEN_W = $clog2(BUF_DEPTH + 1);
    localparam int unsigned SPAN  = (BUF_DEPTH > MIN_LEN) ? BUF_DEPTH : MIN_LEN;
    localparam int unsigned CNT_W = $clog2(SPAN + 1);
    localparam int unsigned ATT_W = $clog2(ATTEMPT_LIMIT + 1);
    localparam int unsigned JC_W  = $clog2(JAM_LEN + 1);

    typedef struct packed {
        txc_state_e         state;
        logic [LEN_W-1:0]   len;
        logic [CNT_W-1:0]   rptr;
        logic [JC_W-1:0]    jcnt;
        logic [ATT_W-1:0]   attempt;
        logic [MAX_EXP-1:0] boff;
        logic               tx_valid;
        logic [7:0]         tx_data;
        logic               done;
        logic               excess;
    } ctl_t;

    ctl_t r_d, r_q;

    logic              buf_we;
    logic [LEN_W-1:0]  wr_idx;
    logic [7:0]        buf_rdata;
    logic              lfsr_step;
    logic [LFSR_W-1:0] lfsr_val;
    logic [ATT_W-1:0]  att_next;
    logic [MAX_EXP-1:0] draw;
    logic [CNT_W-1:0]  len_ext;
    logic [CNT_W-1:0]  send_len;

    txc_frame_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) frame_buf_i (
        .clk_i   (clk_i),
        .we_i    (buf_we),
        .waddr_i (wr_idx[AW-1:0]),
        .wdata_i (in_data_i),
        .raddr_i (r_q.rptr[AW-1:0]),
        .rdata_o (buf_rdata)
    );

    txc_lfsr #(.SEED(LFSR_SEED)) lfsr_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (lfsr_step),
        .value_o (lfsr_val)
    );

    txc_draw #(.MAX_EXP(MAX_EXP), .ATT_W(ATT_W), .SRC_W(LFSR_W)) draw_i (
        .attempt_i (att_next),
        .rand_i    (lfsr_val),
        .slots_o   (draw)
    );

    assign wr_idx   = in_sof_i ? '0 : r_q.len;
    assign att_next = r_q.attempt + ATT_W'(1);
    assign len_ext  = CNT_W'(r_q.len);
    assign send_len = (len_ext < CNT_W'(MIN_LEN)) ? CNT_W'(MIN_LEN) : len_ext;

    always_comb begin
        r_d          = r_q;
        r_d.tx_valid = 1'b0;
        r_d.tx_data  = '0;
        r_d.done     = 1'b0;
        r_d.excess   = 1'b0;
        buf_we       = 1'b0;
        lfsr_step    = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (in_valid_i) begin
                    if (wr_idx < LEN_W'(BUF_DEPTH)) begin
                        buf_we  = 1'b1;
                        r_d.len = wr_idx + LEN_W'(1);
                    end
                    if (in_last_i) begin
                        r_d.state   = ST_DEFER;
                        r_d.attempt = '0;
                    end
                end
            end
            ST_DEFER: begin
                if (!carrier_sense_i) begin
                    r_d.state = ST_SEND;
                    r_d.rptr  = '0;
                end
            end
            ST_SEND: begin
                r_d.tx_valid = 1'b1;
                if (collision_i) begin
                    r_d.tx_data = JAM_BYTE;
                    r_d.jcnt    = JC_W'(1);
                    r_d.state   = ST_JAM;
                end else begin
                    r_d.tx_data = (r_q.rptr < len_ext) ? buf_rdata : 8'h00;
                    r_d.rptr    = r_q.rptr + CNT_W'(1);
                    if (r_q.rptr == send_len - CNT_W'(1)) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.len   = '0;
                    end
                end
            end
            ST_JAM: begin
                r_d.tx_valid = 1'b1;
                r_d.tx_data  = JAM_BYTE;
                r_d.jcnt     = r_q.jcnt + JC_W'(1);
                if (r_q.jcnt == JC_W'(JAM_LEN - 1)) begin
                    if (att_next == ATT_W'(ATTEMPT_LIMIT)) begin
                        r_d.state   = ST_IDLE;
                        r_d.excess  = 1'b1;
                        r_d.len     = '0;
                        r_d.attempt = '0;
                    end else begin
                        lfsr_step   = 1'b1;
                        r_d.attempt = att_next;
                        r_d.boff    = draw;
                        r_d.state   = (draw == '0) ? ST_DEFER : ST_BACKOFF;
                    end
                end
            end
            ST_BACKOFF: begin
                if (slot_tick_i) begin
                    r_d.boff = r_q.boff - MAX_EXP'(1);
                    if (r_q.boff == MAX_EXP'(1)) begin
                        r_d.state = ST_DEFER;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready_o  = (r_q.state == ST_IDLE);
    assign tx_valid_o  = r_q.tx_valid;
    assign tx_data_o   = r_q.tx_data;
    assign tx_done_o   = r_q.done;
    assign tx_excess_o = r_q.excess;

    // R3
    defer_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_DEFER && carrier_sense_i) |=> !tx_valid_o);

    // R6
    jam_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_SEND && collision_i) |=> (tx_valid_o && tx_data_o == JAM_BYTE));

    // R7
    backoff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_BACKOFF && !slot_tick_i) |=>
            (r_q.state == ST_BACKOFF && $stable(r_q.boff)));

    // R2
    len_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_DEFER || r_q.state == ST_BACKOFF) |=> $stable(r_q.len));

    // R5
    done_with_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_done_o |-> (tx_valid_o && !tx_excess_o));

    // R10
    drop_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_excess_o |-> (in_ready_o && tx_valid_o && tx_data_o == JAM_BYTE));

    // R10
    attempt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.attempt < ATT_W'(ATTEMPT_LIMIT));
endmodule

// File: tb/csma_tx_ctrl_tb_top.sv
`timescale 1ns/1ps
module csma_tx_ctrl_tb_top;
    localparam logic [15:0] SEED = 16'hACE1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = '0;
    logic       cs = 1'b0, collision = 1'b0, slot_tick = 1'b0;
    logic       in_ready, tx_valid, tx_done, tx_excess;
    logic [7:0] tx_data;

    int n_checks = 0;
    int n_fail   = 0;
    string tag = "R1";

    always #10 clk = ~clk;   // 50 MHz

    csma_tx_ctrl #(.LFSR_SEED(SEED)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_sof_i(in_sof), .in_last_i(in_last),
        .in_ready_o(in_ready),
        .carrier_sense_i(cs), .collision_i(collision), .slot_tick_i(slot_tick),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_done_o(tx_done), .tx_excess_o(tx_excess)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // slot tick: one pulse every fourth cycle
    int tick_div = 0;
    always @(posedge clk) begin
        #2;
        tick_div = (tick_div + 1) % 4;
        slot_tick = (tick_div == 0);
    end

    // ---------------- behavioural reference ----------------
    int m_ph = 0;            // 0 load, 1 wait medium, 2 sending, 3 jamming, 4 waiting slots
    logic [7:0] m_q[$];
    int m_rp = 0, m_jc = 0, m_att = 0, m_wait = 0;
    logic [15:0] m_lf = SEED;
    bit e_valid = 0, e_done = 0, e_exc = 0;
    logic [7:0] e_data = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_q.delete(); m_att = 0; m_lf = SEED;
            e_valid = 0; e_data = 0; e_done = 0; e_exc = 0;
        end else begin
            e_valid = 0; e_data = 0; e_done = 0; e_exc = 0;
            case (m_ph)
                0: if (in_valid) begin
                    if (in_sof) m_q.delete();
                    m_q.push_back(in_data);
                    if (in_last) begin m_ph = 1; m_att = 0; end
                end
                1: if (!cs) begin m_ph = 2; m_rp = 0; end
                2: begin
                    e_valid = 1;
                    if (collision) begin
                        e_data = 8'hAA; m_jc = 1; m_ph = 3;
                    end else begin
                        int total;
                        total = (m_q.size() < 64) ? 64 : m_q.size();
                        e_data = (m_rp < m_q.size()) ? m_q[m_rp] : 8'h00;
                        m_rp++;
                        if (m_rp == total) begin m_ph = 0; e_done = 1; m_q.delete(); end
                    end
                end
                3: begin
                    e_valid = 1; e_data = 8'hAA; m_jc++;
                    if (m_jc == 4) begin
                        m_att++;
                        if (m_att == 16) begin
                            m_ph = 0; e_exc = 1; m_q.delete(); m_att = 0;
                        end else begin
                            int ex;
                            ex = (m_att < 10) ? m_att : 10;
                            m_wait = int'(m_lf) & ((1 << ex) - 1);
                            m_lf = {m_lf[14:0], m_lf[15] ^ m_lf[13] ^ m_lf[12] ^ m_lf[10]};
                            m_ph = (m_wait == 0) ? 1 : 4;
                        end
                    end
                end
                4: if (slot_tick) begin
                    m_wait--;
                    if (m_wait == 0) m_ph = 1;
                end
                default: m_ph = 0;
            endcase
        end
    end

    // ---------------- monitor and per-cycle compare ----------------
    int n_done = 0, n_exc = 0, n_bytes = 0, n_jam = 0;
    logic [7:0] starts[$];
    bit pv = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            check(tag, "tx_valid", tx_valid, e_valid);
            check(tag, "tx_data", tx_data, e_data);
            check(tag, "tx_done", tx_done, e_done);
            check(tag, "tx_excess", tx_excess, e_exc);
            check(tag, "in_ready", in_ready, m_ph == 0);
            if (tx_valid && !pv) starts.push_back(tx_data);
            if (tx_valid) n_bytes++;
            if (tx_valid && tx_data == 8'hAA) n_jam++;
            if (tx_done) n_done++;
            if (tx_excess) n_exc++;
            pv = tx_valid;
        end
    end

    task automatic clr_mon();
        n_done = 0; n_exc = 0; n_bytes = 0; n_jam = 0; starts.delete();
    endtask

    task automatic load_frame(input int n, input int base, input bit finish);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            in_valid = 1; in_data = 8'(base + i * 3); in_sof = (i == 0);
            in_last = finish && (i == n - 1);
        end
        @(posedge clk); #2;
        in_valid = 0; in_sof = 0; in_last = 0;
    endtask

    task automatic wait_end();
        do @(negedge clk); while (!(tx_done || tx_excess));
        repeat (3) @(posedge clk);
        #2;
    endtask

    task automatic collide_after(input int k, input int hold);
        int seen;
        bit p;
        p = tx_valid;
        forever begin
            @(negedge clk);
            if (tx_valid && !p) break;
            p = tx_valid;
        end
        seen = 1;
        while (seen < k) begin
            @(negedge clk);
            if (tx_valid) seen++;
        end
        @(posedge clk); #2; collision = 1;
        repeat (hold) @(posedge clk);
        #2; collision = 0;
    endtask

    // watchdog
    initial begin
        repeat (180000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check("R1", "tx_valid in reset", tx_valid, 0);
        check("R1", "in_ready in reset", in_ready, 1);
        check("R1", "tx_done in reset", tx_done, 0);
        check("R1", "tx_excess in reset", tx_excess, 0);
        rst_n = 1;
        repeat (2) @(posedge clk);
        #2;
        check("R1", "in_ready after reset", in_ready, 1);

        // R5: short frame padded to 64
        tag = "R5"; clr_mon();
        load_frame(10, 8'h10, 1);
        wait_end();
        check("R5", "short frame byte count", n_bytes, 64);
        check("R5", "short frame done pulses", n_done, 1);

        // R3 / R4: carrier busy first, then toggled during sending
        tag = "R3"; clr_mon(); cs = 1;
        load_frame(80, 8'h21, 1);
        repeat (20) @(posedge clk);
        #2;
        check("R3", "bytes while carrier busy", n_bytes, 0);
        cs = 0;
        tag = "R4";
        repeat (10) @(posedge clk);
        #2; cs = 1;
        repeat (5) @(posedge clk);
        #2; cs = 0;
        wait_end();
        check("R4", "long frame byte count", n_bytes, 80);
        check("R4", "long frame done pulses", n_done, 1);

        // R6 / R7 / R9 / R11: collisions mid-frame, junk input while busy
        tag = "R6"; clr_mon();
        load_frame(20, 8'h33, 1);
        fork
            begin
                repeat (5) begin
                    @(posedge clk); #2;
                    in_valid = 1; in_data = 8'hEE; in_sof = 1; in_last = 1;
                end
                @(posedge clk); #2;
                in_valid = 0; in_sof = 0; in_last = 0;
            end
            collide_after(5, 3);
        join
        tag = "R7";
        collide_after(3, 1);
        tag = "R9";
        wait_end();
        check("R9", "attempts observed", starts.size(), 3);
        foreach (starts[i]) check("R9", "first byte of attempt", starts[i], 8'h33);
        check("R11", "done after retries", n_done, 1);
        check("R6", "jam bytes over two collisions", n_jam, 8);

        // R2: restart with a new start marker
        tag = "R2"; clr_mon();
        load_frame(5, 8'h50, 0);
        load_frame(12, 8'h61, 1);
        wait_end();
        check("R2", "first byte after restart", (starts.size() > 0) ? starts[0] : -1, 8'h61);
        check("R2", "byte count after restart", n_bytes, 64);

        // R10 / R8: every attempt collides
        tag = "R8"; clr_mon(); collision = 1;
        load_frame(8, 8'h71, 1);
        tag = "R10";
        wait_end();
        collision = 0;
        check("R10", "excess pulses", n_exc, 1);
        check("R10", "done pulses when dropped", n_done, 0);
        check("R10", "jam bytes over 16 attempts", n_jam, 64);
        check("R10", "in_ready after drop", in_ready, 1);

        // after drop a fresh frame still goes out
        tag = "R5"; clr_mon();
        load_frame(70, 8'h05, 1);
        wait_end();
        check("R5", "frame after drop byte count", n_bytes, 70);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule